// File: doc/BRIEF.md
# Memory-Mapped Console Port

This block is a console peripheral on a simple 32-bit register bus. Software writes a character register to send one byte on an outgoing valid/ready byte stream. Bytes from an incoming valid/ready stream collect in a 128-entry receive queue, and software reads the queue occupancy back through a count register. A level interrupt goes high when interrupts are on and the queue holds data. Software turns interrupts on and off by writing command codes to one command register, not by setting bits.

Bulk transfers go through a separate DMA mover. Software loads a 64-bit buffer address and a 32-bit length, then writes a command. The port raises a one-cycle start pulse with the transfer description and stays busy until the mover returns a done pulse. For a send transfer, the mover moves the bytes itself. For a receive transfer, the mover pulls the oldest queued bytes out through a valid/ready drain stream, one byte per handshake.

Back-pressure rules:
- The incoming stream is accepted only while the queue has space.
- A pending outgoing byte is held stable until the sink takes it.
- The drain stream offers bytes only while a receive transfer still has bytes left to hand over.

Faults never halt the block. They set a sticky error flag.

Top module: `console_port`

## Requirements
- R1: After reset: `irq`, `err`, `tx_valid`, `dma_start` and `drain_valid` are 0, `rx_ready` is 1, the byte count reads 0, and the address and length registers are 0.
- R2: A write to offset 0x00 puts bits [7:0] of the write data on `tx_data` with `tx_valid` high from the next cycle. The byte is held until `tx_ready` is seen high. A character write made while a byte is still pending and `tx_ready` is low is discarded.
- R3: An incoming byte is taken on `rx_valid && rx_ready` and appended behind older bytes. `rx_ready` is high exactly while fewer than 128 bytes are queued. Offset 0x04 reads the current count, zero-extended.
- R4: A read of offset 0x20 returns the constant 1.
- R5: Command 1 at offset 0x08 turns interrupts on and command 0 turns them off. `irq` is high exactly when interrupts are on and the count is nonzero. Turning them on with data queued raises `irq` in the next cycle.
- R6: Command 2, given while idle, produces a one-cycle `dma_start` in the next cycle with `dma_dir` = 0. `dma_addr` is {offset 0x18, offset 0x10} and `dma_len` is offset 0x14.
- R7: Command 3, given while idle with length <= count, produces a `dma_start` with `dma_dir` = 1. The drain stream then hands over exactly `length` bytes, oldest first. The count drops by one per handshake, so `irq` falls when the queue empties.
- R8: Command 3 with a length greater than the count sets `err` and starts nothing.
- R9: A read of any offset other than 0x04 or 0x20 returns 0 and sets `err`. A write to an offset not among 0x00, 0x08, 0x10, 0x14 and 0x18 sets `err`. A command value above 3 sets `err`. None of these changes anything else. `err` stays set until reset.
- R10: Command 2 or 3 given while a transfer is busy sets `err` and is ignored. The busy state ends on `dma_done`.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Outgoing sink ready |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Queue has space |
| rx_data | input | 8 | Incoming byte |
| irq | output | 1 | Level interrupt |
| err | output | 1 | Sticky fault flag |
| dma_start | output | 1 | One-cycle transfer start |
| dma_dir | output | 1 | 0 send, 1 receive |
| dma_addr | output | 64 | Buffer address of the transfer |
| dma_len | output | 32 | Byte length of the transfer |
| dma_done | input | 1 | Mover finished the transfer |
| drain_valid | output | 1 | Queued byte offered to the mover |
| drain_ready | input | 1 | Mover takes the offered byte |
| drain_data | output | 8 | Oldest queued byte |

## Verification
The hardest case to reach is a receive transfer draining a full queue while the incoming stream keeps pushing. In that case `rx_ready` rises after the first pop, and a push and a pop then land in the same cycle. The stimulus fills all 128 entries, starts a four-byte receive, and drives `rx_valid` whenever `rx_ready` is high during the drain. A second receive then empties the queue. Its byte order must show the old tail followed by the bytes pushed during the first drain.

// File: rtl/console_pkg.sv
package console_pkg;
  localparam int unsigned OFS_CHAR   = 'h00;
  localparam int unsigned OFS_COUNT  = 'h04;
  localparam int unsigned OFS_CMD    = 'h08;
  localparam int unsigned OFS_PTR_LO = 'h10;
  localparam int unsigned OFS_LEN    = 'h14;
  localparam int unsigned OFS_PTR_HI = 'h18;
  localparam int unsigned OFS_VER    = 'h20;

  localparam logic [31:0] PORT_VERSION = 32'd1;

  typedef enum logic [1:0] {
    CMD_IRQ_OFF = 2'd0,
    CMD_IRQ_ON  = 2'd1,
    CMD_SEND    = 2'd2,
    CMD_FETCH   = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] len;
  } xfer_desc_t;
endpackage

// File: rtl/console_rxbuf.sv
module console_rxbuf #(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [7:0]       push_data,
  output logic             push_ready,
  input  logic             pop_en,
  output logic [7:0]       pop_data,
  output logic [CNT_W-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign push_ready = (count < CNT_W'(DEPTH));
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_en && (count != '0);
  assign pop_data   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R3
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && !pop_en) |=> count == $past(count) + CNT_W'(1)); // R3
endmodule

// File: rtl/console_xfer.sv
module console_xfer
  import console_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_send,
  input  logic             cmd_fetch,
  input  xfer_desc_t       desc,
  input  logic [CNT_W-1:0] buf_count,
  output logic             xfer_err,
  output logic             dma_start,
  output logic             dma_dir,
  output logic [63:0]      dma_addr,
  output logic [31:0]      dma_len,
  input  logic             dma_done,
  output logic             drain_valid,
  input  logic             drain_ready,
  output logic             pop_en
);
  logic        busy;
  logic [31:0] remaining;
  logic        ok_send, ok_fetch;

  assign ok_send  = cmd_send && !busy;
  assign ok_fetch = cmd_fetch && !busy && (desc.len <= 32'(buf_count));
  assign xfer_err = (cmd_send && !ok_send) || (cmd_fetch && !ok_fetch);

  assign drain_valid = busy && dma_dir && (remaining != '0);
  assign pop_en      = drain_valid && drain_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      dma_start <= 1'b0;
      dma_dir   <= 1'b0;
      dma_addr  <= '0;
      dma_len   <= '0;
      remaining <= '0;
    end else begin
      dma_start <= 1'b0;
      if (ok_send || ok_fetch) begin
        busy      <= 1'b1;
        dma_start <= 1'b1;
        dma_dir   <= ok_fetch;
        dma_addr  <= desc.addr;
        dma_len   <= desc.len;
        remaining <= ok_fetch ? desc.len : '0;
      end else begin
        if (busy && dma_done) busy <= 1'b0;
        if (pop_en) remaining <= remaining - 32'd1;
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start); // R6
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_send || cmd_fetch) && busy) |=> !dma_start); // R10
endmodule

// File: rtl/console_regs.sv
module console_regs
  import console_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic [CNT_W-1:0]  buf_count,
  input  logic              xfer_err,
  output logic              cmd_send,
  output logic              cmd_fetch,
  output xfer_desc_t        desc,
  output logic              irq,
  output logic              err
);
  logic        irq_en;
  logic [31:0] ptr_lo, ptr_hi, len_q;
  logic        wr_char, wr_cmd, wr_known, rd_known;
  logic        cmd_bad, wr_fault, rd_fault;
  logic [31:0] rd_value;

  assign wr_char  = bus_wr_en && (bus_addr == ADDR_W'(OFS_CHAR));
  assign wr_cmd   = bus_wr_en && (bus_addr == ADDR_W'(OFS_CMD));
  assign wr_known = (bus_addr == ADDR_W'(OFS_CHAR))   || (bus_addr == ADDR_W'(OFS_CMD)) ||
                    (bus_addr == ADDR_W'(OFS_PTR_LO)) || (bus_addr == ADDR_W'(OFS_LEN)) ||
                    (bus_addr == ADDR_W'(OFS_PTR_HI));
  assign rd_known = (bus_addr == ADDR_W'(OFS_COUNT)) || (bus_addr == ADDR_W'(OFS_VER));

  assign cmd_bad   = wr_cmd && (bus_wdata[31:2] != '0);
  assign cmd_send  = wr_cmd && !cmd_bad && (cmd_e'(bus_wdata[1:0]) == CMD_SEND);
  assign cmd_fetch = wr_cmd && !cmd_bad && (cmd_e'(bus_wdata[1:0]) == CMD_FETCH);
  assign wr_fault  = (bus_wr_en && !wr_known) || cmd_bad;
  assign rd_fault  = bus_rd_en && !rd_known;

  assign desc.addr = {ptr_hi, ptr_lo};
  assign desc.len  = len_q;
  assign irq       = irq_en && (buf_count != '0);

  always_comb begin
    rd_value = '0;
    if (bus_addr == ADDR_W'(OFS_COUNT))    rd_value = 32'(buf_count);
    else if (bus_addr == ADDR_W'(OFS_VER)) rd_value = PORT_VERSION;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en    <= 1'b0;
      ptr_lo    <= '0;
      ptr_hi    <= '0;
      len_q     <= '0;
      err       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_rd_en) bus_rdata <= rd_value;
      if (wr_fault || rd_fault || xfer_err) err <= 1'b1;
      if (bus_wr_en) begin
        if (bus_addr == ADDR_W'(OFS_PTR_LO)) ptr_lo <= bus_wdata;
        if (bus_addr == ADDR_W'(OFS_PTR_HI)) ptr_hi <= bus_wdata;
        if (bus_addr == ADDR_W'(OFS_LEN))    len_q  <= bus_wdata;
      end
      if (wr_cmd && !cmd_bad) begin
        if (cmd_e'(bus_wdata[1:0]) == CMD_IRQ_ON)  irq_en <= 1'b1;
        if (cmd_e'(bus_wdata[1:0]) == CMD_IRQ_OFF) irq_en <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (wr_char && (!tx_valid || tx_ready)) begin
      tx_valid <= 1'b1;
      tx_data  <= bus_wdata[7:0];
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(OFS_CMD) && bus_wdata == 32'd0) |=> !irq); // R5
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(OFS_CMD) && bus_wdata == 32'd1 && buf_count > CNT_W'(1))
      |=> irq); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
endmodule

// File: rtl/console_port.sv
module console_port
  import console_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              irq,
  output logic              err,
  output logic              dma_start,
  output logic              dma_dir,
  output logic [63:0]       dma_addr,
  output logic [31:0]       dma_len,
  input  logic              dma_done,
  output logic              drain_valid,
  input  logic              drain_ready,
  output logic [7:0]        drain_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic             pop_en, cmd_send, cmd_fetch, xfer_err;
  xfer_desc_t       desc;

  console_rxbuf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n),
    .push_valid(rx_valid), .push_data(rx_data), .push_ready(rx_ready),
    .pop_en(pop_en), .pop_data(drain_data), .count(count)
  );

  console_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .buf_count(count), .xfer_err(xfer_err),
    .cmd_send(cmd_send), .cmd_fetch(cmd_fetch), .desc(desc),
    .irq(irq), .err(err)
  );

  console_xfer #(.CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .cmd_send(cmd_send), .cmd_fetch(cmd_fetch), .desc(desc),
    .buf_count(count), .xfer_err(xfer_err),
    .dma_start(dma_start), .dma_dir(dma_dir), .dma_addr(dma_addr),
    .dma_len(dma_len), .dma_done(dma_done),
    .drain_valid(drain_valid), .drain_ready(drain_ready), .pop_en(pop_en)
  );

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && !pop_en) |=> !rx_ready); // R3
endmodule

// File: tb/test_console_port.sv
module test_console_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en, bus_rd_en;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ready;
  logic [7:0]  rx_data;
  logic        irq, err, dma_start, dma_dir, dma_done;
  logic [63:0] dma_addr;
  logic [31:0] dma_len;
  logic        drain_valid, drain_ready;
  logic [7:0]  drain_data;

  int n_checks = 0;
  int n_fails  = 0;

  console_port i_console_port (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .irq(irq), .err(err),
    .dma_start(dma_start), .dma_dir(dma_dir), .dma_addr(dma_addr),
    .dma_len(dma_len), .dma_done(dma_done),
    .drain_valid(drain_valid), .drain_ready(drain_ready), .drain_data(drain_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bus_wr_en = 0; bus_rd_en = 0; bus_addr = '0; bus_wdata = '0;
    tx_ready = 0; rx_valid = 0; rx_data = '0; dma_done = 0; drain_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    dma_done = 1;
    @(negedge clk);
    dma_done = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 irq", irq, 0);
    chk("R1 err", err, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 dma_start", dma_start, 0);
    chk("R1 drain_valid", drain_valid, 0);
    chk("R1 rx_ready", rx_ready, 1);
    rd(12'h004, v);
    chk("R1 count", v, 0);
    wr(12'h008, 32'd2);
    chk("R1 addr zero", dma_addr, 64'd0);
    chk("R1 len zero", dma_len, 32'd0);
  endtask

  task automatic t_char();
    do_reset();
    wr(12'h000, 32'h0000_01A5);
    chk("R2 tx_valid", tx_valid, 1);
    chk("R2 tx_data", tx_data, 8'hA5);
    wr(12'h000, 32'h33);
    chk("R2 held byte", tx_data, 8'hA5);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    chk("R2 released", tx_valid, 0);
    chk("R2 no err", err, 0);
  endtask

  task automatic t_version();
    logic [31:0] v;
    do_reset();
    rd(12'h020, v);
    chk("R4 R11 version", v, 32'd1);
    chk("R4 no err", err, 0);
  endtask

  task automatic t_undef();
    logic [31:0] v;
    do_reset();
    rd(12'h00C, v);
    chk("R9 undef read data", v, 0);
    chk("R9 undef read err", err, 1);
    do_reset();
    wr(12'h030, 32'hFFFF_FFFF);
    chk("R9 undef write err", err, 1);
    rd(12'h004, v);
    chk("R9 count untouched", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    do_reset();
    wr(12'h008, 32'd1);
    chk("R5 enabled empty", irq, 0);
    push(8'h11);
    chk("R5 data arrives", irq, 1);
    wr(12'h008, 32'd0);
    chk("R5 disable drops", irq, 0);
    push(8'h22);
    chk("R5 still off", irq, 0);
    wr(12'h008, 32'd1);
    chk("R5 enable with data", irq, 1);
    wr(12'h008, 32'd5);
    chk("R9 bad cmd err", err, 1);
    chk("R9 bad cmd irq kept", irq, 1);
    wr(12'h014, 32'd2);
    wr(12'h008, 32'd3);
    chk("R7 start", dma_start, 1);
    chk("R7 dir", dma_dir, 1);
    drain_ready = 1;
    @(negedge clk);
    chk("R7 irq still high", irq, 1);
    @(negedge clk);
    drain_ready = 0;
    chk("R7 irq falls empty", irq, 0);
    rd(12'h004, v);
    chk("R7 count zero", v, 0);
  endtask

  task automatic t_full_drain();
    logic [31:0] v;
    int pushed = 0;
    int bad = 0;
    do_reset();
    for (int k = 0; k < 128; k++) begin
      @(negedge clk); rx_valid = 1; rx_data = 8'(k);
    end
    @(negedge clk);
    chk("R3 ready low full", rx_ready, 0);
    rx_data = 8'hEE;
    @(negedge clk);
    rx_valid = 0;
    rd(12'h004, v);
    chk("R3 count full", v, 128);
    wr(12'h010, 32'h0000_4000);
    wr(12'h018, 32'h0000_0009);
    wr(12'h014, 32'd4);
    wr(12'h008, 32'd3);
    chk("R7 start", dma_start, 1);
    chk("R7 dir", dma_dir, 1);
    chk("R7 addr", dma_addr, 64'h0000_0009_0000_4000);
    chk("R7 len", dma_len, 32'd4);
    for (int k = 0; k < 4; k++) begin
      if (!(drain_valid && drain_data == 8'(k))) bad++;
      drain_ready = 1;
      rx_valid = rx_ready;
      rx_data = 8'(8'hC0 + k);
      if (rx_ready) pushed++;
      @(negedge clk);
    end
    drain_ready = 0; rx_valid = 0;
    chk("R7 drain order", bad, 0);
    chk("R3 pushes during drain", pushed, 3);
    chk("R7 drain stops", drain_valid, 0);
    rd(12'h004, v);
    chk("R3 count after drain", v, 127);
    pulse_done();
    wr(12'h014, 32'd127);
    wr(12'h008, 32'd3);
    chk("R10 restart after done", dma_start, 1);
    bad = 0;
    for (int k = 0; k < 127; k++) begin
      logic [7:0] e;
      e = (k < 124) ? 8'(k + 4) : 8'(8'hC1 + (k - 124));
      if (!(drain_valid && drain_data == e)) bad++;
      drain_ready = 1;
      @(negedge clk);
    end
    drain_ready = 0;
    chk("R3 append order", bad, 0);
    rd(12'h004, v);
    chk("R7 emptied", v, 0);
    chk("R3 no err", err, 0);
  endtask

  task automatic t_toolong();
    do_reset();
    push(8'h01);
    push(8'h02);
    wr(12'h014, 32'd5);
    wr(12'h008, 32'd3);
    chk("R8 no start", dma_start, 0);
    chk("R8 err", err, 1);
  endtask

  task automatic t_send_busy();
    do_reset();
    wr(12'h010, 32'h0000_1000);
    wr(12'h018, 32'h0000_0002);
    wr(12'h014, 32'd7);
    wr(12'h008, 32'd2);
    chk("R6 start", dma_start, 1);
    chk("R6 dir", dma_dir, 0);
    chk("R6 addr", dma_addr, 64'h0000_0002_0000_1000);
    chk("R6 len", dma_len, 32'd7);
    @(negedge clk);
    chk("R6 one cycle", dma_start, 0);
    wr(12'h008, 32'd2);
    chk("R10 busy no start", dma_start, 0);
    chk("R10 busy err", err, 1);
    pulse_done();
    wr(12'h008, 32'd2);
    chk("R10 idle again", dma_start, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_char();
    t_version();
    t_undef();
    t_irq();
    t_full_drain();
    t_toolong();
    t_send_busy();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule